// File: doc/BRIEF.md
# Serial-Loaded Segmented DAC Controller

This block is the digital front end of a segmented digital-to-analog converter. A host writes 24-bit frames over a three-wire serial link: an active-low frame-select line, a serial clock and a data line. The block carries the three lines into the system clock domain and shifts in one data bit on each falling serial-clock edge, most significant bit first. A frame commits only when its 24th bit arrives. A frame that is cut short has no effect.

A committed frame updates two things together: a 16-bit converter code and a 2-bit output-termination mode. The code drives the converter core directly. Its upper four bits become a 15-line equal-weight thermometer code for the coarse segments. Its lower twelve bits drive the switches of a binary ladder. The mode selects either normal output or one of three powered-down termination states. The system clock must run at least four times faster than the serial clock.

Top module: `seg_dac_serial_if`

## Requirements
- R1: After reset the committed code is 0x8000, the mode is 00, seg_en_o is 0x00FF, ladder_o is 0 and commit_o is low.
- R2: While frame-select is low, each falling serial-clock edge shifts one data bit in, most significant bit first. In the 24-bit frame, bits 23 to 18 are ignored, bits 17:16 are the mode and bits 15:0 are the code.
- R3: On the 24th falling edge of a frame, code_o and mode_o both take the frame's values in the same cycle, and commit_o is high for exactly that one cycle.
- R4: If frame-select rises before the 24th falling edge, code_o and mode_o keep their values and commit_o stays low. The next frame shifts in from a cleared register.
- R5: Falling edges after the 24th, while frame-select is still low, are ignored. A new frame starts only after frame-select has gone high and then low again.
- R6: mode_o reports the committed mode field: 00 normal, 01 ground through 1 kΩ, 10 ground through 100 kΩ, 11 three-state. All four encodings are accepted.
- R7: seg_en_o[i] is 1 exactly when i < code_o[15:12]. A value of N therefore enables N segments, starting from the lowest-numbered one.
- R8: ladder_o always equals code_o[11:0].
- R9: Serial-clock edges while frame-select is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock; data is captured on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| seg_en_o | output | 15 | Thermometer segment enables for the coarse segments |
| ladder_o | output | 12 | Binary ladder switch controls |
| code_o | output | 16 | Committed converter code |
| mode_o | output | 2 | Committed output-termination mode |
| commit_o | output | 1 | One-cycle strobe when a frame commits |

## Verification
Random full frames carry random values in the ignored top bits. This shows that only the mode and code fields reach the outputs, and that the ladder and thermometer paths follow every coarse value. Directed frames use each of the four mode encodings and the coarse values 0 and 15, which separates a correct thermometer from one shifted by a single position. Aborted frames of random length are each followed by a full frame. These show that nothing commits early and that no leftover bits leak into the next frame. Frames with extra clocks after the 24th, and clocks sent while frame-select is idle, show that those edges neither shift data nor cause a second commit.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    parameter int FRAME_BITS   = 24;
    parameter int CODE_W       = 16;
    parameter int MODE_W       = 2;
    parameter int COARSE_BITS  = 4;

    localparam int SEG_N    = (1 << COARSE_BITS) - 1;
    localparam int LAD_W    = CODE_W - COARSE_BITS;
    localparam int CNT_W    = $clog2(FRAME_BITS + 1);
    localparam int MODE_LSB = CODE_W;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_GND_1K   = 2'b01,
        MODE_GND_100K = 2'b10,
        MODE_TRISTATE = 2'b11
    } term_mode_e;

    typedef enum logic [1:0] {
        FS_READY = 2'b00,
        FS_SHIFT = 2'b01,
        FS_DONE  = 2'b10
    } frame_st_e;

    typedef struct packed {
        frame_st_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sr;
        logic                  sclk_prev;
        logic                  strobe;
    } frame_s;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [MODE_W-1:0] mode;
        logic              commit;
    } core_s;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
    import sdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  strobe_o
);
    frame_s fr_d, fr_q;
    logic   sclk_fall;

    always_comb begin
        fr_d           = fr_q;
        fr_d.strobe    = 1'b0;
        fr_d.sclk_prev = sclk_s;
        sclk_fall      = fr_q.sclk_prev & ~sclk_s;
        unique case (fr_q.st)
            FS_READY: begin
                if (!sel_n_s) begin
                    fr_d.st  = FS_SHIFT;
                    fr_d.cnt = '0;
                    fr_d.sr  = '0;
                end
            end
            FS_SHIFT: begin
                if (sel_n_s) begin
                    fr_d.st  = FS_READY;
                    fr_d.cnt = '0;
                    fr_d.sr  = '0;
                end else if (sclk_fall) begin
                    fr_d.sr = {fr_q.sr[FRAME_BITS-2:0], sdi_s};
                    if (fr_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                        fr_d.st     = FS_DONE;
                        fr_d.cnt    = '0;
                        fr_d.strobe = 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            FS_DONE: begin
                if (sel_n_s) fr_d.st = FS_READY;
            end
            default: fr_d.st = FS_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q.st        <= FS_READY;
            fr_q.cnt       <= '0;
            fr_q.sr        <= '0;
            fr_q.sclk_prev <= 1'b0;
            fr_q.strobe    <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign frame_o  = fr_q.sr;
    assign strobe_o = fr_q.strobe;
endmodule

// File: rtl/sdac_core_reg.sv
module sdac_core_reg
    import sdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  strobe_i,
    output logic [CODE_W-1:0]     code_o,
    output logic [MODE_W-1:0]     mode_o,
    output logic                  commit_o
);
    core_s cr_d, cr_q;

    always_comb begin
        cr_d        = cr_q;
        cr_d.commit = strobe_i;
        if (strobe_i) begin
            cr_d.code = frame_i[CODE_W-1:0];
            cr_d.mode = frame_i[MODE_LSB +: MODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q.code   <= CODE_MID;
            cr_q.mode   <= MODE_W'(MODE_NORMAL);
            cr_q.commit <= 1'b0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign code_o   = cr_q.code;
    assign mode_o   = cr_q.mode;
    assign commit_o = cr_q.commit;
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
    import sdac_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_N-1:0]  seg_en_o,
    output logic [LAD_W-1:0]  ladder_o
);
    logic [COARSE_BITS-1:0] coarse;

    assign coarse   = code_i[CODE_W-1 -: COARSE_BITS];
    assign ladder_o = code_i[LAD_W-1:0];

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        assign seg_en_o[g] = (coarse > COARSE_BITS'(g));
    end
endmodule

// File: rtl/seg_dac_serial_if.sv
module seg_dac_serial_if
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic [SEG_N-1:0]  seg_en_o,
    output logic [LAD_W-1:0]  ladder_o,
    output logic [CODE_W-1:0] code_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              commit_o
);
    logic [2:0]            pins_s;
    logic [FRAME_BITS-1:0] frame;
    logic                  strobe;

    sdac_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_n_i, sclk_i, sdi_i}),
        .sync_o  (pins_s)
    );

    sdac_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_s  (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .frame_o  (frame),
        .strobe_o (strobe)
    );

    sdac_core_reg u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame),
        .strobe_i (strobe),
        .code_o   (code_o),
        .mode_o   (mode_o),
        .commit_o (commit_o)
    );

    sdac_decode u_dec (
        .code_i   (code_o),
        .seg_en_o (seg_en_o),
        .ladder_o (ladder_o)
    );
endmodule

// File: rtl/sdac_checker.sv
module sdac_checker
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SEG_N-1:0]  seg_en,
    input logic [CODE_W-1:0] code,
    input logic [MODE_W-1:0] mode,
    input logic              commit
);
    AST_SEG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_en) == int'(code[CODE_W-1 -: COARSE_BITS])); // R7

    AST_SEG_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en & (seg_en + SEG_N'(1))) == '0); // R7

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> ($stable(code) && $stable(mode))); // R4

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R3
endmodule

bind seg_dac_serial_if sdac_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .seg_en (seg_en_o),
    .code   (code_o),
    .mode   (mode_o),
    .commit (commit_o)
);

// File: tb/tb_seg_dac_serial_if.sv
module tb_seg_dac_serial_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [14:0] seg_en;
    logic [11:0] ladder;
    logic [15:0] code;
    logic [1:0]  mode;
    logic        commit;

    int n_chk = 0;
    int n_bad = 0;
    int n_commit = 0;
    int exp_commit = 0;
    logic [15:0] exp_code;
    logic [1:0]  exp_mode;
    bit          finished = 0;

    always #4 clk = ~clk;

    seg_dac_serial_if dut (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
        .seg_en_o(seg_en), .ladder_o(ladder), .code_o(code), .mode_o(mode),
        .commit_o(commit)
    );

    always @(posedge clk) if (rst_n && commit) n_commit++;

    function automatic logic [14:0] thermo(input logic [3:0] n);
        logic [14:0] t = '0;
        for (int i = 0; i < 15; i++) if (i < int'(n)) t[i] = 1'b1;
        return t;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2/R3 code"}, 32'(code), 32'(exp_code));
        chk({tag, " R6 mode"}, 32'(mode), 32'(exp_mode));
        chk({tag, " R7 seg_en"}, 32'(seg_en), 32'(thermo(exp_code[15:12])));
        chk({tag, " R8 ladder"}, 32'(ladder), 32'(exp_code[11:0]));
        chk({tag, " R3 commit count"}, 32'(n_commit), 32'(exp_commit));
    endtask

    // nbits < 24 aborts; nbits > 24 adds trailing clocks while still selected
    task automatic send(input logic [23:0] f, input int nbits);
        sel_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 24) ? f[23-i] : 1'($urandom);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        sel_n = 1'b1;
        wait_clk(8);
        if (nbits >= 24) begin
            exp_code = f[15:0];
            exp_mode = f[17:16];
            exp_commit++;
        end
    endtask

    task automatic stray_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            sdi  = 1'($urandom);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
        end
        wait_clk(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0D1C));
        exp_code = 16'h8000;
        exp_mode = 2'b00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        chk("R1 code", 32'(code), 32'h8000);
        chk("R1 mode", 32'(mode), 32'h0);
        chk("R1 seg_en", 32'(seg_en), 32'h00FF);
        chk("R1 ladder", 32'(ladder), 32'h0);
        chk("R1 commit", 32'(commit), 32'h0);

        // R9 clocks while idle
        stray_clocks(30);
        check_all("R9 idle clocks");

        // R6 every mode, R7 coarse extremes
        send({6'h3F, 2'b01, 16'h0000}, 24); check_all("R6 mode01 coarse0");
        send({6'h00, 2'b10, 16'hFFFF}, 24); check_all("R6 mode10 coarse15");
        send({6'h15, 2'b11, 16'h1ABC}, 24); check_all("R6 mode11");
        send({6'h2A, 2'b00, 16'hE001}, 24); check_all("R6 mode00");

        // R4 aborted frames, then a clean full frame
        send(24'hFFFFFF, 23); check_all("R4 abort at 23");
        send(24'hFFFFFF, 1);  check_all("R4 abort at 1");
        send(24'h00_1234, 24); check_all("R4 clean after abort");

        // R5 trailing clocks with select held
        send(24'h02_7F00, 40); check_all("R5 trailing clocks");

        for (int k = 0; k < 120; k++) begin
            logic [23:0] f = 24'($urandom);
            int r = int'($urandom_range(0, 9));
            if (r == 0) begin
                send(f, int'($urandom_range(1, 23)));
                check_all("R4 random abort");
            end else if (r == 1) begin
                send(f, 24 + int'($urandom_range(1, 12)));
                check_all("R5 random trailing");
            end else begin
                send(f, 24);
                check_all("R2 random frame");
            end
            if (k % 20 == 0) begin
                stray_clocks(5);
                check_all("R9 random idle clocks");
            end
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule